// File: doc/BRIEF.md
# Word-Serial Montgomery Modular Multiplier

This block multiplies two residues modulo an odd prime `q` of the form `q = q_hi·2^W + 1` and returns the Montgomery-scaled product `Z = A·B·2^(−T·W) mod q`. It first forms the full product of the operands. It then removes `W` low-order bits per step over `T` pipelined reduction steps. Each step exploits `q ≡ 1 (mod 2^W)`: the correction digit is simply the negated low word, and the multiply needs only the high part of the modulus.

The modulus is an input that travels with its operands. Any prime of the required shape whose width lies between `W+1` and `MAX_K` bits (with `MAX_K ≤ T·W`) can be used, and the modulus may change from one operation to the next. A single conditional subtraction brings the result into `[0, q)`. The unit accepts one operation per clock and has a fixed latency of `T+2` cycles. Conversion into and out of the Montgomery domain is done elsewhere.

Top module: `mont_word_mul`

## Requirements
- R1: For operands `A, B < q`, each result equals `A·B·inv(2^(T·W)) mod q`, using the modulus presented with those operands.
- R2: Every result lies in `[0, q)`, and before the final subtraction the reduced value is below `2q`.
- R3: A result appears on `out_valid`/`out_z` exactly `T+2` rising edges after its operands are sampled (6 with the defaults), counting the sampling edge.
- R4: Operands with a different modulus may be issued on consecutive cycles. Each result uses only its own modulus.
- R5: Any modulus with `in_mod[W-1:0] == 1` and `in_mod[MAX_K-1:W] != 0` is accepted, from the smallest (`2^W+1`) up to full `MAX_K`-bit width.
- R6: `out_valid` is low after reset. It then pulses once for each sampled `in_valid`, preserving gaps.
- R7: Corner operands give correct results: a zero operand gives 0, and `A = B = q−1` and `A = B = 1` are handled.
- R8: An operation in flight when `rst` is asserted produces no `out_valid` afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and modulus valid this cycle |
| in_a | input | MAX_K | First operand, below the modulus |
| in_b | input | MAX_K | Second operand, below the modulus |
| in_mod | input | MAX_K | Modulus `q_hi·2^W + 1` |
| out_valid | output | 1 | Result valid |
| out_z | output | MAX_K | `A·B·2^(−T·W) mod q` |

## Verification
Each result is due `T+2` rising edges after its operands are sampled. The bench carries its own reference value, validity and modulus through a `T+2`-deep delay line. It compares them with the outputs on the falling edge that follows the edge on which the result lands. A separate directed test counts falling edges from one isolated issue to the first `out_valid` and expects exactly `T+2`. The reset test holds `in_valid` low and watches for that many cycles plus margin. All operand pairs are swept for two small primes and a 9-bit prime, with random pairs at full width and with the modulus alternating every cycle.

// File: rtl/mont_pkg.sv
package mont_pkg;
  localparam int unsigned DEF_WORD_W = 4;
  localparam int unsigned DEF_ITER   = 4;
  localparam int unsigned DEF_MAX_K  = 16;

  // cycles from operand sampling edge to result: product + T steps + final subtract
  function automatic int unsigned mont_latency(input int unsigned iter);
    return iter + 2;
  endfunction
endpackage

// File: rtl/mont_product.sv
module mont_product #(
  parameter int unsigned MAX_K = 16,
  parameter int unsigned ZW    = 2 * MAX_K + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             v_i,
  input  logic [MAX_K-1:0] a_i,
  input  logic [MAX_K-1:0] b_i,
  input  logic [MAX_K-1:0] q_i,
  output logic             v_o,
  output logic [ZW-1:0]    z_o,
  output logic [MAX_K-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst) v_o <= 1'b0;
    else     v_o <= v_i;
    z_o <= ZW'(a_i) * ZW'(b_i);
    q_o <= q_i;
  end
endmodule

// File: rtl/mont_reduce_step.sv
module mont_reduce_step #(
  parameter int unsigned W     = 4,
  parameter int unsigned MAX_K = 16,
  parameter int unsigned ZW    = 2 * MAX_K + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             v_i,
  input  logic [ZW-1:0]    z_i,
  input  logic [MAX_K-1:0] q_i,
  output logic             v_o,
  output logic [ZW-1:0]    z_o,
  output logic [MAX_K-1:0] q_o
);
  localparam int unsigned QHW = MAX_K - W;

  logic [W-1:0]   low_w;
  logic [W-1:0]   digit;
  logic [QHW-1:0] q_hi;
  logic [ZW-1:0]  z_nxt;

  // (z + digit*q) >> W == (z >> W) + digit*q_hi + (low word nonzero)
  always_comb begin
    low_w = z_i[W-1:0];
    digit = -low_w;
    q_hi  = q_i[MAX_K-1:W];
    z_nxt = (z_i >> W) + ZW'(digit) * ZW'(q_hi) + ZW'(|low_w);
  end

  always_ff @(posedge clk) begin
    if (rst) v_o <= 1'b0;
    else     v_o <= v_i;
    z_o <= z_nxt;
    q_o <= q_i;
  end

  // R5: modulus must be congruent to 1 mod 2^W and wider than W bits
  a_r5_modulus_form: assert property (@(posedge clk) disable iff (rst)
    v_i |-> (q_i[W-1:0] == W'(1)) && (q_hi != '0));
endmodule

// File: rtl/mont_final_sub.sv
module mont_final_sub #(
  parameter int unsigned MAX_K = 16,
  parameter int unsigned ZW    = 2 * MAX_K + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             v_i,
  input  logic [ZW-1:0]    z_i,
  input  logic [MAX_K-1:0] q_i,
  output logic             v_o,
  output logic [MAX_K-1:0] z_o
);
  logic             ge_q;
  logic [MAX_K-1:0] z_red;

  always_comb begin
    ge_q  = z_i >= ZW'(q_i);
    z_red = ge_q ? (z_i[MAX_K-1:0] - q_i) : z_i[MAX_K-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) v_o <= 1'b0;
    else     v_o <= v_i;
    z_o <= z_red;
  end

  // R2: one subtraction suffices only if the reduced value is below 2q
  a_r2_pre_bound: assert property (@(posedge clk) disable iff (rst)
    v_i |-> (z_i < (ZW'(q_i) << 1)));

  // R2: result lies in [0, q)
  a_r2_out_range: assert property (@(posedge clk) disable iff (rst)
    v_o |-> (z_o < $past(q_i)));
endmodule

// File: rtl/mont_word_mul.sv
module mont_word_mul #(
  parameter int unsigned W     = mont_pkg::DEF_WORD_W,
  parameter int unsigned T     = mont_pkg::DEF_ITER,
  parameter int unsigned MAX_K = mont_pkg::DEF_MAX_K
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [MAX_K-1:0] in_a,
  input  logic [MAX_K-1:0] in_b,
  input  logic [MAX_K-1:0] in_mod,
  output logic             out_valid,
  output logic [MAX_K-1:0] out_z
);
  localparam int unsigned ZW  = 2 * MAX_K + 1;
  localparam int unsigned LAT = mont_pkg::mont_latency(T);
  localparam int unsigned CW  = $clog2(LAT + 1) + 1;

  logic             v_s [0:T];
  logic [ZW-1:0]    z_s [0:T];
  logic [MAX_K-1:0] q_s [0:T];

  mont_product #(.MAX_K(MAX_K), .ZW(ZW)) u_prod (
    .clk(clk), .rst(rst),
    .v_i(in_valid), .a_i(in_a), .b_i(in_b), .q_i(in_mod),
    .v_o(v_s[0]), .z_o(z_s[0]), .q_o(q_s[0])
  );

  for (genvar i = 0; i < T; i++) begin : g_step
    mont_reduce_step #(.W(W), .MAX_K(MAX_K), .ZW(ZW)) u_step (
      .clk(clk), .rst(rst),
      .v_i(v_s[i]),   .z_i(z_s[i]),   .q_i(q_s[i]),
      .v_o(v_s[i+1]), .z_o(z_s[i+1]), .q_o(q_s[i+1])
    );
  end

  mont_final_sub #(.MAX_K(MAX_K), .ZW(ZW)) u_fin (
    .clk(clk), .rst(rst),
    .v_i(v_s[T]), .z_i(z_s[T]), .q_i(q_s[T]),
    .v_o(out_valid), .z_o(out_z)
  );

  // edges since reset release, saturating; bounds the $past window below
  logic [CW-1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                    since_rst <= '0;
    else if (since_rst < CW'(LAT)) since_rst <= since_rst + 1'b1;
  end

  // R3 and R6: each sampled operand produces exactly one result LAT edges later
  a_r3_fixed_latency: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= CW'(LAT)) |-> (out_valid == $past(in_valid, LAT)));
endmodule

// File: tb/test_mont_word_mul.sv
`timescale 1ns/1ps
module test_mont_word_mul;
  localparam int unsigned W     = mont_pkg::DEF_WORD_W;
  localparam int unsigned T     = mont_pkg::DEF_ITER;
  localparam int unsigned MAX_K = mont_pkg::DEF_MAX_K;
  localparam int unsigned LAT   = mont_pkg::mont_latency(T);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic [MAX_K-1:0] in_a = '0, in_b = '0, in_mod = 17;
  logic             out_valid;
  logic [MAX_K-1:0] out_z;

  always #2.5 clk = ~clk;

  mont_word_mul #(.W(W), .T(T), .MAX_K(MAX_K)) i_mont_word_mul (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .in_mod(in_mod), .out_valid(out_valid), .out_z(out_z)
  );

  int    n_checks = 0;
  int    n_fail   = 0;
  string tag      = "R1";
  bit    done     = 1'b0;

  // A*B*inv(2^(T*W)) mod q, by halving modulo q T*W times
  function automatic longint ref_mont(longint a, longint b, longint q);
    longint p = (a * b) % q;
    longint h = (q + 1) / 2;
    for (int i = 0; i < int'(T * W); i++) p = (p * h) % q;
    return p;
  endfunction

  // reference delay line of LAT stages
  logic   mv [LAT];
  longint me [LAT];
  longint mq [LAT];
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(LAT); i++) mv[i] <= 1'b0;
    end else begin
      mv[0] <= in_valid;
      me[0] <= ref_mont(longint'(in_a), longint'(in_b), longint'(in_mod));
      mq[0] <= longint'(in_mod);
      for (int i = 1; i < int'(LAT); i++) begin
        mv[i] <= mv[i-1]; me[i] <= me[i-1]; mq[i] <= mq[i-1];
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && (mv[LAT-1] || out_valid)) begin
      n_checks++;
      if (out_valid !== mv[LAT-1]) begin
        n_fail++;
        $display("FAIL R6 out_valid actual=%0b expected=%0b", out_valid, mv[LAT-1]);
      end else if (longint'(out_z) != me[LAT-1]) begin
        n_fail++;
        $display("FAIL %s value q=%0d actual=%0d expected=%0d", tag, mq[LAT-1], out_z, me[LAT-1]);
      end
      if (out_valid) begin
        n_checks++;
        if (longint'(out_z) >= mq[LAT-1]) begin
          n_fail++;
          $display("FAIL R2 range actual=%0d expected below %0d", out_z, mq[LAT-1]);
        end
      end
    end
  end

  task automatic issue(input longint a, input longint b, input longint q);
    @(negedge clk);
    in_valid = 1'b1; in_a = MAX_K'(a); in_b = MAX_K'(b); in_mod = MAX_K'(q);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic sweep(input longint q);
    for (longint a = 0; a < q; a++)
      for (longint b = 0; b < q; b++) issue(a, b, q);
    idle(LAT + 2);
  endtask

  initial begin
    #(5ns * 190000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    n_checks++;
    if (out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R6 reset out_valid actual=%0b expected=0", out_valid);
    end
    @(negedge clk); rst = 1'b0;
    idle(2);

    // R3: isolated operation, count falling edges to first out_valid
    begin
      int seen = 0;
      issue(3, 5, 17);
      for (int k = 1; k <= 10; k++) begin
        @(negedge clk);
        if (k == 1) in_valid = 1'b0;
        if (out_valid && seen == 0) seen = k;
      end
      n_checks++;
      if (seen != int'(LAT)) begin
        n_fail++;
        $display("FAIL R3 latency actual=%0d expected=%0d", seen, LAT);
      end
    end

    // R1: exhaustive sweeps; R5: smallest legal modulus 2^W+1 included
    tag = "R5"; sweep(17);
    tag = "R1"; sweep(97);
    sweep(257);

    // R5: full-width modulus, random operands
    tag = "R5";
    for (int i = 0; i < 3000; i++) issue($urandom % 65521, $urandom % 65521, 65521);
    idle(LAT + 2);

    // R4: modulus changes every cycle, with gaps (R6)
    tag = "R4";
    for (int i = 0; i < 3000; i++) begin
      longint q;
      case (i % 3)
        0: q = 97;
        1: q = 65521;
        default: q = 257;
      endcase
      issue($urandom % q, $urandom % q, q);
      if (i % 7 == 3) idle(1);
    end
    idle(LAT + 2);

    // R7: corner operands
    tag = "R7";
    issue(0, 12345, 65521);
    issue(40000, 0, 65521);
    issue(65520, 65520, 65521);
    issue(1, 1, 65521);
    issue(256, 256, 257);
    issue(16, 16, 17);
    idle(LAT + 2);

    // R8: reset while operations are in flight
    tag = "R8";
    for (int i = 0; i < 3; i++) issue(i + 2, i + 7, 97);
    @(negedge clk); in_valid = 1'b0; rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    begin
      int pulses = 0;
      for (int k = 0; k < int'(LAT) + 4; k++) begin
        @(negedge clk);
        if (out_valid) pulses++;
      end
      n_checks++;
      if (pulses != 0) begin
        n_fail++;
        $display("FAIL R8 pulses after reset actual=%0d expected=0", pulses);
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule